// File: doc/BRIEF.md
# Battery-backed SRAM bus controller

This block sits between an on-chip host and an external 32K x 8 asynchronous static RAM that keeps its contents on battery. The host issues single-byte reads and writes over a request/acknowledge port. The controller turns each request into a timed sequence on the memory's active-low chip-select, write-strobe and read-enable lines, with a 15-bit address and an 8-bit data path. The data path is split into an output value, an output-enable and an input value, and the pad ring resolves them onto the shared bus.

Each phase of a memory cycle lasts a whole number of clock cycles set by a parameter. The write pulse length also sets the data setup before the write ends. There are also a data hold after the write, a read access window and a recovery gap before the next cycle. A supply-fault input marks the main supply as out of tolerance. While it is high, write requests are refused with an error acknowledge and the memory is never strobed. Reads continue as normal.

Top module: `nvram_bus_ctrl`

## Requirements
- R1: During and right after reset `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0 and `host_ack` and `host_err` are 0.
- R2: A write holds `mem_ce_n` and `mem_we_n` low together for exactly SETUP_CYC cycles, with `mem_oe_n` high, `mem_dq_oe` high, and `mem_addr` and `mem_dq_o` unchanged for the whole pulse. Both strobes rise on the same edge.
- R3: After a write pulse ends, `mem_dq_oe` stays high with the same data and address for exactly HOLD_CYC cycles, and the strobes stay high.
- R4: A read holds `mem_ce_n` and `mem_oe_n` low with `mem_we_n` high and `mem_dq_oe` low for exactly ACC_CYC cycles. It captures `mem_dq_i` on the last edge of that window and returns it on `host_rdata` together with `host_ack`.
- R5: Between any two memory cycles `mem_ce_n` stays high for at least REC_CYC cycles.
- R6: A write requested while `supply_bad` is 1 produces no strobe. It is acknowledged with `host_ack`=1 and `host_err`=1, and the memory location keeps its old value.
- R7: A read requested while `supply_bad` is 1 is performed normally, and `host_err` is 0.
- R8: `host_ack` is a one-cycle pulse per request. `host_err` is 0 for every completed read or write. A request is taken only while the controller is idle, and the host drops `host_req` in the cycle after it sees `host_ack`.
- R9: The data driver is never enabled while `mem_oe_n` is low, and it is released before any read enables the memory outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Request, held until `host_ack` |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 15 | Byte address |
| host_wdata | input | 8 | Write byte |
| host_ack | output | 1 | One-cycle completion pulse |
| host_err | output | 1 | With `host_ack`: write refused by supply fault |
| host_rdata | output | 8 | Read byte, valid with `host_ack` |
| supply_bad | input | 1 | Main supply out of tolerance |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory read enable, active low |
| mem_addr | output | 15 | Memory address |
| mem_dq_o | output | 8 | Data driven toward memory |
| mem_dq_oe | output | 1 | Enable for the data driver |
| mem_dq_i | input | 8 | Data returned by memory |

## Verification
A sequencer stuck in or skipping a phase shows up at once as a wrong strobe width. The behavioural memory model measures every write pulse, hold window and read window and compares them with the parameters within a few cycles of the cycle's end. A latch that picks up the address or data at the wrong moment breaks the stability checks during the pulse. It also shows up on the next read of that address as a wrong byte. A supply-fault path that leaks gives a write strobe or a changed byte that a later read exposes, and a missing error flag is seen in the same acknowledge.

// File: rtl/nvram_pkg.sv
// Shared types for the battery-backed SRAM controller.
// Holds the sequencer state encoding and the strobe decode used by
// the strobe register, so both sides agree on what each phase drives.
package nvram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WPULSE  = 3'd1,
        ST_WHOLD   = 3'd2,
        ST_RACC    = 3'd3,
        ST_RECOVER = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } strobe_t;

    // Strobe levels that belong to each sequencer phase.
    function automatic strobe_t strobes_for(input seq_state_t st);
        strobe_t s;
        s = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
        case (st)
            ST_WPULSE: begin
                s.ce_n  = 1'b0;
                s.we_n  = 1'b0;
                s.dq_oe = 1'b1;
            end
            ST_WHOLD: s.dq_oe = 1'b1;
            ST_RACC: begin
                s.ce_n = 1'b0;
                s.oe_n = 1'b0;
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/nvram_phase_timer.sv
// Down-counter that times one sequencer phase.
// Assumes: load value is (phase length - 1); done is high in the last
// cycle of the phase. Load wins over counting.
module nvram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Count down the current phase, reload on phase entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/nvram_seq_fsm.sv
// Cycle sequencer: picks the phase order for reads, writes and refused
// writes, and loads the phase timer on each phase entry.
// Assumes: the host holds a request until acknowledged; supply_bad is
// sampled once, when the request is taken.
module nvram_seq_fsm
    import nvram_pkg::*;
#(
    parameter int ACC_CYC   = 2,
    parameter int SETUP_CYC = 2,
    parameter int HOLD_CYC  = 1,
    parameter int REC_CYC   = 1,
    parameter int CNT_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_req,
    input  logic             host_wr,
    input  logic             supply_bad,
    input  logic             t_done,
    output seq_state_t       state_nxt,
    output logic             t_load,
    output logic [CNT_W-1:0] t_val,
    output logic             accept,
    output logic             finish,
    output logic             capture,
    output logic             blocked
);
    localparam logic [CNT_W-1:0] ACC_LD   = CNT_W'(ACC_CYC - 1);
    localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LD   = CNT_W'(REC_CYC - 1);

    seq_state_t state_q;

    // Next phase and timer reload from the current phase.
    always_comb begin
        state_nxt = state_q;
        t_load    = 1'b0;
        t_val     = '0;
        accept    = 1'b0;
        finish    = 1'b0;
        capture   = 1'b0;
        blocked   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (host_req) begin
                    accept = 1'b1;
                    t_load = 1'b1;
                    if (host_wr && supply_bad) begin
                        blocked   = 1'b1;
                        state_nxt = ST_RECOVER;
                        t_val     = REC_LD;
                    end else if (host_wr) begin
                        state_nxt = ST_WPULSE;
                        t_val     = SETUP_LD;
                    end else begin
                        state_nxt = ST_RACC;
                        t_val     = ACC_LD;
                    end
                end
            end
            ST_WPULSE: begin
                if (t_done) begin
                    state_nxt = ST_WHOLD;
                    t_load    = 1'b1;
                    t_val     = HOLD_LD;
                end
            end
            ST_WHOLD: begin
                if (t_done) begin
                    state_nxt = ST_RECOVER;
                    t_load    = 1'b1;
                    t_val     = REC_LD;
                    finish    = 1'b1;
                end
            end
            ST_RACC: begin
                if (t_done) begin
                    state_nxt = ST_RECOVER;
                    t_load    = 1'b1;
                    t_val     = REC_LD;
                    finish    = 1'b1;
                    capture   = 1'b1;
                end
            end
            ST_RECOVER: begin
                if (t_done) begin
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

endmodule

// File: rtl/nvram_strobe_reg.sv
// Registers the memory strobes from the next phase so that each pin
// leaves a flop and changes exactly on a phase boundary.
// Assumes: phase decode comes from nvram_pkg::strobes_for.
module nvram_strobe_reg
    import nvram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_t state_nxt,
    output logic       mem_ce_n,
    output logic       mem_we_n,
    output logic       mem_oe_n,
    output logic       mem_dq_oe
);
    strobe_t nxt_s;
    strobe_t cur_s;

    assign nxt_s = strobes_for(state_nxt);

    // Strobe flops, all inactive in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_s <= '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
        end else begin
            cur_s <= nxt_s;
        end
    end

    assign mem_ce_n  = cur_s.ce_n;
    assign mem_we_n  = cur_s.we_n;
    assign mem_oe_n  = cur_s.oe_n;
    assign mem_dq_oe = cur_s.dq_oe;

endmodule

// File: rtl/nvram_host_latch.sv
// Host-side datapath: holds address and write byte for the whole memory
// cycle, captures the read byte, and produces the ack/err pulse.
// Assumes: accept only in idle, so the latched values never move while
// a memory cycle is under way.
module nvram_host_latch #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              capture,
    input  logic              finish,
    input  logic              blocked,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              ack_q,
    output logic              err_q
);
    // Request latch: address and write byte, taken at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
        end
    end

    // Read capture at the last edge of the access window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= mem_dq_i;
        end
    end

    // Completion pulse and refusal flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            ack_q <= finish | blocked;
            err_q <= blocked;
        end
    end

endmodule

// File: rtl/nvram_bus_ctrl.sv
// Top: battery-backed SRAM bus controller. Turns single-byte host
// requests into timed strobe sequences on an asynchronous SRAM and
// refuses writes while the supply is flagged out of tolerance.
// Assumes: every *_CYC parameter is at least 1; the data bus is split
// into out/enable/in and resolved in the pad ring.
module nvram_bus_ctrl
    import nvram_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int ACC_CYC   = 2,
    parameter int SETUP_CYC = 2,
    parameter int HOLD_CYC  = 1,
    parameter int REC_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic              host_err,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              supply_bad,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int MAX_AB  = (ACC_CYC > SETUP_CYC) ? ACC_CYC : SETUP_CYC;
    localparam int MAX_CD  = (HOLD_CYC > REC_CYC) ? HOLD_CYC : REC_CYC;
    localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    seq_state_t       state_nxt;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_done;
    logic             accept;
    logic             finish;
    logic             capture;
    logic             op_blocked;

    nvram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    nvram_seq_fsm #(
        .ACC_CYC   (ACC_CYC),
        .SETUP_CYC (SETUP_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .REC_CYC   (REC_CYC),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_wr    (host_wr),
        .supply_bad (supply_bad),
        .t_done     (t_done),
        .state_nxt  (state_nxt),
        .t_load     (t_load),
        .t_val      (t_val),
        .accept     (accept),
        .finish     (finish),
        .capture    (capture),
        .blocked    (op_blocked)
    );

    nvram_strobe_reg u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_nxt (state_nxt),
        .mem_ce_n  (mem_ce_n),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .mem_dq_oe (mem_dq_oe)
    );

    nvram_host_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .capture    (capture),
        .finish     (finish),
        .blocked    (op_blocked),
        .mem_dq_i   (mem_dq_i),
        .addr_q     (mem_addr),
        .wdata_q    (mem_dq_o),
        .rdata_q    (host_rdata),
        .ack_q      (host_ack),
        .err_q      (host_err)
    );

endmodule

// File: rtl/nvram_bus_ctrl_chk.sv
// Checker for nvram_bus_ctrl, bound to every instance of the top.
// Watches the memory-side strobes and the host handshake over time.
module nvram_bus_ctrl_chk #(
    parameter int ADDR_W  = 15,
    parameter int DATA_W  = 8,
    parameter int REC_CYC = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_ack,
    input logic              host_err,
    input logic              op_blocked,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_o
);
    localparam int HC_W = $clog2(REC_CYC + 2);
    localparam logic [HC_W-1:0] HC_CAP = HC_W'(REC_CYC);

    logic [HC_W-1:0] hi_cnt;

    // Consecutive cycles with chip select high, saturating at REC_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= HC_CAP;
        end else if (!mem_ce_n) begin
            hi_cnt <= '0;
        end else if (hi_cnt < HC_CAP) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assert_no_contention_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    assert_write_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

    assert_write_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));

    assert_write_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_ce_n && mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_o)));

    assert_read_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n && !mem_dq_oe));

    assert_recovery_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> (hi_cnt >= HC_CAP));

    assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    assert_refused_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_blocked |=> (host_ack && host_err && mem_we_n && mem_ce_n));

    assert_err_with_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |-> host_ack);

endmodule

bind nvram_bus_ctrl nvram_bus_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .REC_CYC (REC_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_ack   (host_ack),
    .host_err   (host_err),
    .op_blocked (op_blocked),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_oe  (mem_dq_oe),
    .mem_addr   (mem_addr),
    .mem_dq_o   (mem_dq_o)
);

// File: tb/nvram_bus_ctrl_tb.sv
// Bench for nvram_bus_ctrl: behavioural SRAM model with timing checks,
// a vector table walked by one loop, then directed corner cases.
module nvram_bus_ctrl_tb;
    localparam int ACC   = 3;
    localparam int SETUP = 2;
    localparam int HOLD  = 2;
    localparam int REC   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic [14:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ack, host_err;
    logic [7:0]  host_rdata;
    logic        supply_bad = 1'b0;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [14:0] mem_addr;
    logic [7:0]  mem_dq_o;
    logic [7:0]  mem_dq_i;

    always #5 clk = ~clk;

    nvram_bus_ctrl #(
        .ACC_CYC(ACC), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .REC_CYC(REC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_err(host_err), .host_rdata(host_rdata), .supply_bad(supply_bad),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i)
    );

    // ---------------- behavioural SRAM with timing checks ----------------
    logic [7:0]  mdl_mem [logic [14:0]];
    logic [7:0]  mdl_rd;
    int          pulse_cnt = 0, hold_left = 0, rcnt = 0, ho_run = 0, hicnt = 0;
    int          last_wpulse = 0, last_racc = 0, last_hold = 0;
    int          mdl_err = 0, wr_strobes = 0, contention = 0;
    logic [14:0] wa = '0, ra = '0;
    logic [7:0]  wd = '0;
    logic        prev_ce_n = 1'b1;

    always_comb begin
        mdl_rd = mdl_mem.exists(mem_addr) ? mdl_mem[mem_addr] : 8'h00;
    end
    // Data is valid only once the access window has run its full length.
    assign mem_dq_i = (!mem_ce_n && !mem_oe_n && mem_we_n && (rcnt + 1 >= ACC)) ? mdl_rd : 8'hEE;

    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe && !mem_oe_n) contention <= contention + 1;
            // write pulse and hold window
            if (!mem_ce_n && !mem_we_n) begin
                if (pulse_cnt == 0) begin
                    wa <= mem_addr; wd <= mem_dq_o;
                    wr_strobes <= wr_strobes + 1;
                end else if (mem_addr != wa || mem_dq_o != wd) mdl_err <= mdl_err + 1;
                if (!mem_oe_n || !mem_dq_oe) mdl_err <= mdl_err + 1;
                pulse_cnt <= pulse_cnt + 1;
            end else if (pulse_cnt != 0) begin
                last_wpulse <= pulse_cnt;
                if (pulse_cnt >= SETUP) mdl_mem[wa] = wd;
                else mdl_err <= mdl_err + 1;
                if (!mem_dq_oe || mem_dq_o != wd || mem_addr != wa) mdl_err <= mdl_err + 1;
                hold_left <= HOLD - 1;
                pulse_cnt <= 0;
            end else if (hold_left > 0) begin
                if (!mem_dq_oe || mem_dq_o != wd || mem_addr != wa) mdl_err <= mdl_err + 1;
                hold_left <= hold_left - 1;
            end
            if (mem_we_n && mem_dq_oe) ho_run <= ho_run + 1;
            else if (ho_run != 0) begin
                last_hold <= ho_run; ho_run <= 0;
            end
            // read window
            if (!mem_ce_n && !mem_oe_n) begin
                if (rcnt == 0) ra <= mem_addr;
                else if (mem_addr != ra) mdl_err <= mdl_err + 1;
                rcnt <= rcnt + 1;
            end else if (rcnt != 0) begin
                last_racc <= rcnt; rcnt <= 0;
            end
            // recovery gap
            if (mem_ce_n) hicnt <= hicnt + 1;
            else begin
                if (prev_ce_n && hicnt < REC) mdl_err <= mdl_err + 1;
                hicnt <= 0;
            end
            prev_ce_n <= mem_ce_n;
        end
    end

    // ---------------- bench bookkeeping ----------------
    int n_checks = 0, n_fail = 0;
    bit done_flag = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    // Issue one request and wait for the acknowledge.
    task automatic run_op(input bit wr, input bit bad, input logic [14:0] a,
                          input logic [7:0] d, output logic [7:0] rd,
                          output logic er, output bit got);
        got = 1'b0; rd = '0; er = 1'b0;
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; supply_bad = bad;
        host_addr = a; host_wdata = d;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (host_ack) begin
                rd = host_rdata; er = host_err; got = 1'b1;
                host_req = 1'b0;
                break;
            end
        end
        host_req = 1'b0;
        // ack must last one cycle only (R8)
        @(negedge clk);
        chk(!host_ack, "R8 ack single pulse", int'(host_ack), 0);
        repeat (3) @(negedge clk);
    endtask

    // wr, bad, addr, data, exp_err, exp_rdata
    localparam logic [33:0] VEC [0:11] = '{
        {1'b1, 1'b0, 15'h0000, 8'h5A, 1'b0, 8'h00},
        {1'b1, 1'b0, 15'h7FFF, 8'hA5, 1'b0, 8'h00},
        {1'b1, 1'b0, 15'h1234, 8'h3C, 1'b0, 8'h00},
        {1'b0, 1'b0, 15'h0000, 8'h00, 1'b0, 8'h5A},
        {1'b0, 1'b0, 15'h7FFF, 8'h00, 1'b0, 8'hA5},
        {1'b1, 1'b1, 15'h1234, 8'hFF, 1'b1, 8'h00},
        {1'b0, 1'b1, 15'h1234, 8'h00, 1'b0, 8'h3C},
        {1'b0, 1'b0, 15'h1234, 8'h00, 1'b0, 8'h3C},
        {1'b1, 1'b0, 15'h4001, 8'h00, 1'b0, 8'h00},
        {1'b0, 1'b0, 15'h4001, 8'h00, 1'b0, 8'h00},
        {1'b1, 1'b0, 15'h2000, 8'h81, 1'b0, 8'h00},
        {1'b0, 1'b0, 15'h2000, 8'h00, 1'b0, 8'h81}
    };

    initial begin
        logic [7:0] rd;
        logic       er;
        bit         got;
        int         strobes_before;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !host_ack && !host_err,
            "R1 reset strobes", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !host_ack,
            "R1 after reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);

        // vector table
        foreach (VEC[i]) begin
            strobes_before = wr_strobes;
            run_op(VEC[i][33], VEC[i][32], VEC[i][31:17], VEC[i][16:9], rd, er, got);
            chk(got, "R8 request acknowledged", int'(got), 1);
            chk(er == VEC[i][8], VEC[i][32] ? "R6 R7 err flag under supply fault" : "R8 err low",
                int'(er), int'(VEC[i][8]));
            if (VEC[i][33] && VEC[i][32]) begin
                chk(wr_strobes == strobes_before, "R6 refused write no strobe",
                    wr_strobes - strobes_before, 0);
            end else if (VEC[i][33]) begin
                chk(last_wpulse == SETUP, "R2 write pulse width", last_wpulse, SETUP);
                chk(last_hold == HOLD, "R3 data hold width", last_hold, HOLD);
            end else begin
                chk(rd == VEC[i][7:0], VEC[i][32] ? "R7 read under supply fault" : "R4 read data",
                    int'(rd), int'(VEC[i][7:0]));
                chk(last_racc == ACC, "R4 access window", last_racc, ACC);
            end
        end

        // directed: write then read at once, recovery and contention
        run_op(1'b1, 1'b0, 15'h0555, 8'hC3, rd, er, got);
        run_op(1'b0, 1'b0, 15'h0555, 8'h00, rd, er, got);
        chk(rd == 8'hC3, "R4 back-to-back read", int'(rd), 8'hC3);
        // refused write to a written location leaves it intact
        run_op(1'b1, 1'b1, 15'h0555, 8'h11, rd, er, got);
        chk(er == 1'b1, "R6 refused write err", int'(er), 1);
        run_op(1'b0, 1'b0, 15'h0555, 8'h00, rd, er, got);
        chk(rd == 8'hC3, "R6 location unchanged", int'(rd), 8'hC3);
        chk(mdl_err == 0, "R2 R3 R5 memory model timing", mdl_err, 0);
        chk(contention == 0, "R9 no driver with read enable", contention, 0);
        chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R5 idle strobes high",
            {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);

        finish_run();
    end

endmodule